// File: doc/BRIEF.md
# Memory-Mapped Peripheral Bus Slave Port

This block is the target side of a simple synchronous on-chip bus for a filter peripheral. A bus master presents an address, write data, a read-not-write flag and a select. The port registers all of these inputs, then checks whether the address falls inside a power-of-two window that sits at a configurable base. For a hit, it returns one acknowledge pulse per access, with read data aligned to that pulse.

On the write side there are two destinations. A one-bit run control takes data bit 0. A coefficient push strobe carries the low 12 data bits toward the filter. On the read side there are three sources: the head word of an output frame FIFO (which also raises a pop strobe), the FIFO full flag and the FIFO empty flag. Burst, byte-lane, retry, timeout-suppress and error responses are not supported, and their outputs are held low.

Top module: `mmio_slave_port`

## Requirements
- R1: While reset is high and in the cycle after it, `xfer_ack`, `rd_data`, `run_o`, `coef_push` and `ofifo_pop` are all zero.
- R2: An access whose address lies outside the window [BASE_ADDR, HIGH_ADDR] gets no acknowledge and raises no strobe, even with `bus_sel` high.
- R3: An address inside the window with `bus_sel` low gets no acknowledge; `xfer_ack` is only ever high two cycles after `bus_sel` was sampled high.
- R4: When `bus_sel` is first presented in cycle N with an in-window address, `xfer_ack` is high in cycle N+2 for exactly one cycle, even if `bus_sel` stays high longer.
- R5: After `bus_sel` drops for at least one cycle and is raised again, the new access gets its own single acknowledge.
- R6: A read at word offset 0 (byte offset 0x0) returns the output FIFO data zero-extended to 32 bits, and pulses `ofifo_pop` in the acknowledge cycle.
- R7: A read at byte offset 0x4 returns the full flag in bit 0, and a read at 0x8 returns the empty flag in bit 0; all other bits are zero.
- R8: A read of any in-window word offset other than 0, 1 or 2 returns zero and pops nothing. Address bits [1:0] are ignored, so 0x5 reads the same as 0x4.
- R9: `rd_data` is zero in every cycle in which `xfer_ack` is low, including write acknowledges.
- R10: A write at byte offset 0x0 loads data bit 0 into `run_o`, and the new value is visible in the cycle after the acknowledge.
- R11: A write at byte offset 0x4 raises `coef_push` in the acknowledge cycle, with `coef_data` equal to write data bits [11:0].
- R12: Reads never change `run_o`. A write at any offset other than 0x0 or 0x4 changes no output except the acknowledge. `retry_o`, `tout_sup_o` and `err_ack_o` are always 0.
- R13: `coef_push` and `ofifo_pop` are only ever high together with `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high bus reset |
| bus_addr | input | 32 | Byte address from the master |
| bus_wdata | input | 32 | Write data from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 1 | Master asserts address valid |
| ofifo_data | input | OUT_DW | Head word of the output frame FIFO |
| ofifo_full | input | 1 | Output FIFO full flag |
| ofifo_empty | input | 1 | Output FIFO empty flag |
| rd_data | output | 32 | Read data, zero outside acknowledge |
| xfer_ack | output | 1 | One-cycle transfer acknowledge |
| retry_o | output | 1 | Retry response, held low |
| tout_sup_o | output | 1 | Timeout suppress, held low |
| err_ack_o | output | 1 | Error response, held low |
| run_o | output | 1 | Run control bit |
| coef_push | output | 1 | Coefficient write strobe |
| coef_data | output | 12 | Coefficient value |
| ofifo_pop | output | 1 | Output FIFO read strobe |

## Verification
The bench holds select for several cycles, because a port that merely registered select would acknowledge repeatedly and hang a master in a loop. It also drops select for a single cycle and then raises it again, since a stuck completion flag would swallow the second acknowledge. Addresses are placed one byte past the high bound and at equal low bits under a different tag, and reads target unmapped offsets and non-zero byte lanes. A decoder that compared too few bits, or only the low offset field, would then alias registers and give false pops or wrong data. The bench also reads right after a run write and writes to a read-only offset, and a strobe decoder that ignored direction would corrupt the run bit.

// File: rtl/mmio_slave_pkg.sv
package mmio_slave_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned COEF_W  = 12;
    localparam int unsigned NUM_STB = 5;

    typedef enum int unsigned {
        STB_RD_DATA  = 0,
        STB_RD_FULL  = 1,
        STB_RD_EMPTY = 2,
        STB_WR_RUN   = 3,
        STB_WR_COEF  = 4
    } stb_e;

    // word offset within the window that each strobe responds to
    function automatic int unsigned stb_word(input int unsigned s);
        case (s)
            STB_RD_DATA:  return 0;
            STB_RD_FULL:  return 1;
            STB_RD_EMPTY: return 2;
            STB_WR_RUN:   return 0;
            default:      return 1;
        endcase
    endfunction

    function automatic logic stb_is_read(input int unsigned s);
        return (s <= STB_RD_EMPTY) ? 1'b1 : 1'b0;
    endfunction

    typedef struct packed {
        logic              sel;
        logic              rnw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_in_t;

endpackage

// File: rtl/mmio_in_stage.sv
module mmio_in_stage
    import mmio_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_in_t bus_i,
    output bus_in_t bus_q
);
    bus_in_t reg_d, reg_q;

    always_comb begin
        reg_d = bus_i;
        if (rst) begin
            reg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        reg_q <= reg_d;
    end

    assign bus_q = reg_q;
endmodule

// File: rtl/mmio_win_decode.sv
module mmio_win_decode #(
    parameter int unsigned          ADDR_W    = 32,
    parameter int unsigned          WIN_BITS  = 8,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = '0,
    localparam int unsigned         OFF_W     = WIN_BITS - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    output logic              hit,
    output logic [OFF_W-1:0]  word_idx
);
    localparam logic [ADDR_W-WIN_BITS-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_BITS];

    logic tag_eq;
    logic [1:0] unused_lane;

    always_comb begin
        tag_eq   = (addr[ADDR_W-1:WIN_BITS] == BASE_TAG);
        hit      = sel & tag_eq;
        word_idx = addr[WIN_BITS-1:2];
    end

    assign unused_lane = addr[1:0];
endmodule

// File: rtl/mmio_strobe_gen.sv
module mmio_strobe_gen
    import mmio_slave_pkg::*;
#(
    parameter int unsigned OFF_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic               rnw,
    input  logic [OFF_W-1:0]   word_idx,
    output logic [NUM_STB-1:0] stb_nxt,
    output logic [NUM_STB-1:0] stb_q,
    output logic               ack_q
);
    localparam int unsigned KEY_W = OFF_W + 2;

    typedef struct packed {
        logic               ack;
        logic               done;
        logic [NUM_STB-1:0] stb;
    } st_t;

    st_t st_d, st_q;
    logic             ack_nxt;
    logic [KEY_W-1:0] key;
    logic [NUM_STB-1:0] match;

    assign ack_nxt = hit & ~st_q.done;
    assign key     = {word_idx, rnw, ack_nxt};

    for (genvar g = 0; g < NUM_STB; g++) begin : g_cmp
        localparam logic [KEY_W-1:0] REF =
            {OFF_W'(stb_word(g)), stb_is_read(g), 1'b1};
        assign match[g] = (key == REF);
    end

    always_comb begin
        st_d      = st_q;
        st_d.ack  = ack_nxt;
        st_d.done = hit & (st_q.done | ack_nxt);
        st_d.stb  = match;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stb_nxt = st_d.stb;
    assign stb_q   = st_q.stb;
    assign ack_q   = st_q.ack;
endmodule

// File: rtl/mmio_rdata_out.sv
module mmio_rdata_out
    import mmio_slave_pkg::*;
#(
    parameter int unsigned OUT_DW = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_STB-1:0] stb_nxt,
    input  logic [OUT_DW-1:0]  ofifo_data,
    input  logic               ofifo_full,
    input  logic               ofifo_empty,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (stb_nxt[STB_RD_DATA]) begin
            rd_d = DATA_W'(ofifo_data);
        end else if (stb_nxt[STB_RD_FULL]) begin
            rd_d = DATA_W'(ofifo_full);
        end else if (stb_nxt[STB_RD_EMPTY]) begin
            rd_d = DATA_W'(ofifo_empty);
        end
        if (rst) begin
            rd_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mmio_slave_port.sv
module mmio_slave_port
    import mmio_slave_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8000_0400,
    parameter logic [31:0] HIGH_ADDR = 32'h8000_04FF,
    parameter int unsigned OUT_DW    = 24
) (
    input  logic              clk,
    input  logic              bus_rst,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rnw,
    input  logic              bus_sel,
    input  logic [OUT_DW-1:0] ofifo_data,
    input  logic              ofifo_full,
    input  logic              ofifo_empty,
    output logic [31:0]       rd_data,
    output logic              xfer_ack,
    output logic              retry_o,
    output logic              tout_sup_o,
    output logic              err_ack_o,
    output logic              run_o,
    output logic              coef_push,
    output logic [11:0]       coef_data,
    output logic              ofifo_pop
);
    localparam logic [31:0] SPAN     = HIGH_ADDR - BASE_ADDR + 32'd1;
    localparam int unsigned WIN_BITS = $clog2(SPAN);
    localparam int unsigned OFF_W    = WIN_BITS - 2;

    typedef struct packed {
        logic              run;
        logic              run_val;
        logic [COEF_W-1:0] coef;
    } ctl_t;

    bus_in_t            bus_i, bus_q;
    logic               hit;
    logic [OFF_W-1:0]   word_idx;
    logic [NUM_STB-1:0] stb_nxt, stb_q;
    logic               ack_q;
    ctl_t               ctl_d, ctl_q;
    logic [DATA_W-COEF_W-2:0] unused_wdata;

    assign bus_i = '{sel: bus_sel, rnw: bus_rnw, addr: bus_addr, wdata: bus_wdata};

    mmio_in_stage u_in (
        .clk   (clk),
        .rst   (bus_rst),
        .bus_i (bus_i),
        .bus_q (bus_q)
    );

    mmio_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr     (bus_q.addr),
        .sel      (bus_q.sel),
        .hit      (hit),
        .word_idx (word_idx)
    );

    mmio_strobe_gen #(
        .OFF_W (OFF_W)
    ) u_stb (
        .clk      (clk),
        .rst      (bus_rst),
        .hit      (hit),
        .rnw      (bus_q.rnw),
        .word_idx (word_idx),
        .stb_nxt  (stb_nxt),
        .stb_q    (stb_q),
        .ack_q    (ack_q)
    );

    mmio_rdata_out #(
        .OUT_DW (OUT_DW)
    ) u_rd (
        .clk         (clk),
        .rst         (bus_rst),
        .stb_nxt     (stb_nxt),
        .ofifo_data  (ofifo_data),
        .ofifo_full  (ofifo_full),
        .ofifo_empty (ofifo_empty),
        .rd_data     (rd_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (stb_q[STB_WR_RUN]) begin
            ctl_d.run = ctl_q.run_val;
        end
        if (stb_nxt[STB_WR_RUN]) begin
            ctl_d.run_val = bus_q.wdata[0];
        end
        if (stb_nxt[STB_WR_COEF]) begin
            ctl_d.coef = bus_q.wdata[COEF_W-1:0];
        end
        if (bus_rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign unused_wdata = bus_q.wdata[DATA_W-1:COEF_W+1];

    assign xfer_ack   = ack_q;
    assign run_o      = ctl_q.run;
    assign coef_push  = stb_q[STB_WR_COEF];
    assign coef_data  = ctl_q.coef;
    assign ofifo_pop  = stb_q[STB_RD_DATA];
    assign retry_o    = 1'b0;
    assign tout_sup_o = 1'b0;
    assign err_ack_o  = 1'b0;
endmodule

// File: rtl/mmio_slave_port_chk.sv
module mmio_slave_port_chk (
    input logic        clk,
    input logic        bus_rst,
    input logic        bus_sel,
    input logic        xfer_ack,
    input logic [31:0] rd_data,
    input logic        run_o,
    input logic        coef_push,
    input logic        ofifo_pop,
    input logic        retry_o,
    input logic        tout_sup_o,
    input logic        err_ack_o
);
    p_ack_single_r4: assert property (@(posedge clk) disable iff (bus_rst)
        xfer_ack |=> !xfer_ack);

    p_ack_needs_sel_r3: assert property (@(posedge clk) disable iff (bus_rst)
        xfer_ack |-> $past(bus_sel, 2));

    p_rdata_idle_zero_r9: assert property (@(posedge clk) disable iff (bus_rst)
        !xfer_ack |-> (rd_data == 32'd0));

    p_strobe_with_ack_r13: assert property (@(posedge clk) disable iff (bus_rst)
        (coef_push || ofifo_pop) |-> xfer_ack);

    p_run_after_ack_r10: assert property (@(posedge clk) disable iff (bus_rst)
        (!$stable(run_o) && !$past(bus_rst)) |-> $past(xfer_ack));

    p_tied_low_r12: assert property (@(posedge clk) disable iff (bus_rst)
        !(retry_o || tout_sup_o || err_ack_o));
endmodule

bind mmio_slave_port mmio_slave_port_chk chk_i (
    .clk        (clk),
    .bus_rst    (bus_rst),
    .bus_sel    (bus_sel),
    .xfer_ack   (xfer_ack),
    .rd_data    (rd_data),
    .run_o      (run_o),
    .coef_push  (coef_push),
    .ofifo_pop  (ofifo_pop),
    .retry_o    (retry_o),
    .tout_sup_o (tout_sup_o),
    .err_ack_o  (err_ack_o)
);

// File: tb/mmio_slave_port_tb_top.sv
`timescale 1ns/1ps
module mmio_slave_port_tb_top;
    localparam logic [31:0] BASE = 32'h8000_0400;
    localparam logic [31:0] HIGH = 32'h8000_04FF;
    localparam int unsigned ODW  = 24;

    logic clk = 1'b0;
    logic bus_rst = 1'b1;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic bus_rnw = 1'b0, bus_sel = 1'b0;
    logic [ODW-1:0] ofifo_data = '0;
    logic ofifo_full = 1'b0, ofifo_empty = 1'b1;
    logic [31:0] rd_data;
    logic xfer_ack, retry_o, tout_sup_o, err_ack_o, run_o, coef_push, ofifo_pop;
    logic [11:0] coef_data;

    always #2.5 clk = ~clk;

    mmio_slave_port #(.BASE_ADDR(BASE), .HIGH_ADDR(HIGH), .OUT_DW(ODW)) dut_i (
        .clk(clk), .bus_rst(bus_rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rnw(bus_rnw), .bus_sel(bus_sel), .ofifo_data(ofifo_data),
        .ofifo_full(ofifo_full), .ofifo_empty(ofifo_empty), .rd_data(rd_data),
        .xfer_ack(xfer_ack), .retry_o(retry_o), .tout_sup_o(tout_sup_o),
        .err_ack_o(err_ack_o), .run_o(run_o), .coef_push(coef_push),
        .coef_data(coef_data), .ofifo_pop(ofifo_pop)
    );

    int cyc = 0, total = 0, bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic m_sel, m_rnw, m_done, m_ack, m_pop, m_push, m_run, m_runwr, m_runval;
    logic [31:0] m_addr, m_wd, m_rd;
    logic [11:0] m_coef;

    function automatic logic in_win(input logic [31:0] a);
        return (a >= BASE) && (a <= HIGH);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (bus_rst) begin
            {m_sel, m_rnw, m_done, m_ack, m_pop, m_push, m_run, m_runwr, m_runval} = '0;
            m_addr = '0; m_wd = '0; m_rd = '0; m_coef = '0;
        end else begin
            logic ps, nack;
            int widx;
            ps     = m_sel && in_win(m_addr);
            nack   = ps && !m_done;
            m_done = ps && (m_done || nack);
            widx   = int'((m_addr - BASE) >> 2);
            if (m_runwr) m_run = m_runval;
            m_runwr  = nack && !m_rnw && (widx == 0);
            m_runval = m_wd[0];
            m_push   = nack && !m_rnw && (widx == 1);
            if (m_push) m_coef = m_wd[11:0];
            m_pop    = nack && m_rnw && (widx == 0);
            if (!(nack && m_rnw))  m_rd = 32'd0;
            else if (widx == 0)    m_rd = {8'd0, ofifo_data};
            else if (widx == 1)    m_rd = {31'd0, ofifo_full};
            else if (widx == 2)    m_rd = {31'd0, ofifo_empty};
            else                   m_rd = 32'd0;
            m_ack  = nack;
            m_sel  = bus_sel; m_rnw = bus_rnw; m_addr = bus_addr; m_wd = bus_wdata;
        end
    end

    // monitor for directed checks
    int ack_cnt = 0, ack_lat = -1, start_cyc = 0;
    logic [31:0] last_rd = '0;
    logic pop_seen = 0, push_seen = 0;

    always @(negedge clk) begin
        if (cyc >= 1) begin
            chk("R4", "ack vs model", 32'(xfer_ack), 32'(m_ack));
            chk("R9", "rd_data vs model", rd_data, m_rd);
            chk("R10", "run vs model", 32'(run_o), 32'(m_run));
            chk("R11", "push vs model", 32'(coef_push), 32'(m_push));
            chk("R11", "coef vs model", 32'(coef_data), 32'(m_coef));
            chk("R6", "pop vs model", 32'(ofifo_pop), 32'(m_pop));
            chk("R12", "tied low", 32'({retry_o, tout_sup_o, err_ack_o}), 32'd0);
            if (xfer_ack) begin
                if (ack_cnt == 0) ack_lat = cyc - start_cyc;
                ack_cnt++;
                last_rd = rd_data;
            end
            if (ofifo_pop) pop_seen = 1'b1;
            if (coef_push) push_seen = 1'b1;
        end
    end

    task automatic access(input logic [31:0] a, input logic [31:0] wd,
                          input logic rnw, input int hold, input logic sv);
        @(negedge clk);
        ack_cnt = 0; ack_lat = -1; pop_seen = 0; push_seen = 0; last_rd = 32'hDEAD_BEEF;
        start_cyc = cyc;
        bus_addr = a; bus_wdata = wd; bus_rnw = rnw; bus_sel = sv;
        repeat (hold) @(negedge clk);
        bus_sel = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ack in reset", 32'(xfer_ack), 32'd0);
        chk("R1", "rd in reset", rd_data, 32'd0);
        chk("R1", "run in reset", 32'(run_o), 32'd0);
        chk("R1", "strobes in reset", 32'({coef_push, ofifo_pop}), 32'd0);
        bus_rst = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after reset", 32'({xfer_ack, run_o, coef_push, ofifo_pop}), 32'd0);

        // R10 run write
        access(BASE, 32'hFFFF_0001, 1'b0, 1, 1'b1);
        chk("R10", "run set", 32'(run_o), 32'd1);
        chk("R9", "write ack rd zero", last_rd, 32'd0);
        // R12 read does not change run, write to 0x8 changes nothing
        access(BASE + 32'h8, 32'h0000_0000, 1'b0, 1, 1'b1);
        chk("R12", "write to ro offset acked", 32'(ack_cnt), 32'd1);
        chk("R12", "run kept after ro write", 32'(run_o), 32'd1);
        chk("R12", "no push on ro write", 32'(push_seen), 32'd0);
        access(BASE, 32'h0, 1'b1, 1, 1'b1);
        chk("R12", "run kept after read", 32'(run_o), 32'd1);
        access(BASE, 32'hFFFF_FFFE, 1'b0, 1, 1'b1);
        chk("R10", "run cleared", 32'(run_o), 32'd0);

        // R11 coefficient
        access(BASE + 32'h4, 32'hABCD_E5A7, 1'b0, 1, 1'b1);
        chk("R11", "push seen", 32'(push_seen), 32'd1);
        chk("R11", "coef value", 32'(coef_data), 32'h5A7);
        chk("R10", "run untouched by coef", 32'(run_o), 32'd0);

        // R6 data read
        ofifo_data = 24'hC35A96;
        access(BASE, 32'h0, 1'b1, 1, 1'b1);
        chk("R6", "fifo data", last_rd, 32'h00C3_5A96);
        chk("R6", "pop seen", 32'(pop_seen), 32'd1);

        // R7 flags
        ofifo_full = 1'b1; ofifo_empty = 1'b0;
        access(BASE + 32'h4, 32'h0, 1'b1, 1, 1'b1);
        chk("R7", "full flag", last_rd, 32'd1);
        chk("R7", "no pop on flag read", 32'(pop_seen), 32'd0);
        access(BASE + 32'h8, 32'h0, 1'b1, 1, 1'b1);
        chk("R7", "empty flag", last_rd, 32'd0);
        ofifo_full = 1'b0; ofifo_empty = 1'b1;
        access(BASE + 32'h8, 32'h0, 1'b1, 1, 1'b1);
        chk("R7", "empty flag set", last_rd, 32'd1);

        // R8 unmapped and byte lane
        access(BASE + 32'hC, 32'h0, 1'b1, 1, 1'b1);
        chk("R8", "unmapped 0xC", last_rd, 32'd0);
        chk("R8", "unmapped acked", 32'(ack_cnt), 32'd1);
        access(BASE + 32'h40, 32'h0, 1'b1, 1, 1'b1);
        chk("R8", "unmapped 0x40", last_rd, 32'd0);
        chk("R8", "no pop alias", 32'(pop_seen), 32'd0);
        access(BASE + 32'h0A, 32'h0, 1'b1, 1, 1'b1);
        chk("R8", "lane bits ignored", last_rd, 32'd1);

        // R2 outside window
        access(HIGH + 32'h1, 32'h1, 1'b0, 1, 1'b1);
        chk("R2", "above high no ack", 32'(ack_cnt), 32'd0);
        access(32'h0000_0400, 32'h1, 1'b0, 1, 1'b1);
        chk("R2", "other tag no ack", 32'(ack_cnt), 32'd0);
        chk("R2", "run untouched", 32'(run_o), 32'd0);

        // R3 select low
        access(BASE, 32'h1, 1'b0, 1, 1'b0);
        chk("R3", "no sel no ack", 32'(ack_cnt), 32'd0);
        chk("R3", "run untouched", 32'(run_o), 32'd0);

        // R4 held select
        access(BASE + 32'h8, 32'h0, 1'b1, 6, 1'b1);
        chk("R4", "single ack while held", 32'(ack_cnt), 32'd1);
        chk("R4", "ack latency", 32'(ack_lat), 32'd2);

        // R5 drop one cycle and reassert
        @(negedge clk);
        ack_cnt = 0; start_cyc = cyc;
        bus_addr = BASE + 32'h4; bus_rnw = 1'b1; bus_sel = 1'b1;
        repeat (3) @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        bus_sel = 1'b1;
        repeat (3) @(negedge clk);
        bus_sel = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5", "two acks for two accesses", 32'(ack_cnt), 32'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule